// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block follows the operating power mode of a chip and decides every mode change. Eight modes exist: high-speed, sleep, subactive, subsleep, watch, software standby, hardware standby and reset. A one-cycle sleep strobe from the CPU samples four configuration bits to select the target mode: a standby-select bit, a direct-transfer bit, a low-speed-on bit and a watchdog prescaler-select bit. A direct transition may skip intermediate modes, for example going straight from high-speed to subactive. A pending interrupt wakes the low-power modes.

Two active-low pins override everything else. The standby pin forces hardware standby. The reset pin forces the reset mode, in which a programmable settling counter stands in for oscillator stabilisation. A reset-exception request is raised only once the pin has been released and the settling time has passed.

From the mode, the block derives a main-clock enable, a subclock select and one clock enable per peripheral group. It also reports two errors. A configuration error shows a nonzero system clock divider while the chip is in subactive mode. A sticky flag records a sleep strobe whose bit combination matches no defined transition.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_n`, `mode` is 7 (reset), `resetReq` is 0 and `illegalFlag` is 0. The mode codes are: 0 high-speed, 1 sleep, 2 subactive, 3 subsleep, 4 watch, 5 software standby, 6 hardware standby, 7 reset.
- R2: When `stbyPin_n` is 0 at a clock edge, `mode` becomes 6 after that edge, whatever the current mode and whatever `resetPin_n` is. When mode is 6 and `stbyPin_n` is 1 at an edge, mode becomes 7.
- R3: When `stbyPin_n` is 1 and `resetPin_n` is 0 at an edge, `mode` becomes 7. Entering mode 7 from any other mode restarts the settling count at zero.
- R4: Mode 7 is left only at an edge where both pins are 1 and at least `settleCount` edges have passed in mode 7 since it was entered. At that edge mode becomes 0 and `resetReq` is 1 for exactly one cycle. Releasing the pin early only defers the exit.
- R5: In mode 0, a sleep strobe selects the next mode as follows:
  - standby-select 0 gives mode 1.
  - standby-select 1 with direct-transfer 0 gives mode 4 if prescaler-select is 1, and mode 5 if it is 0.
  - standby-select 1, direct-transfer 1, low-speed-on 1 and prescaler-select 1 give mode 2.
- R6: In mode 2, a sleep strobe with prescaler-select 1 selects the next mode as follows:
  - standby-select 1 with direct-transfer 0 gives mode 4.
  - standby-select 0 with low-speed-on 1 gives mode 3.
  - standby-select 1, direct-transfer 1 and low-speed-on 0 give mode 0.
- R7: An interrupt (`irqPend` 1) wakes the low-power modes:
  - modes 1 and 5 go to 0.
  - mode 3 goes to 2.
  - mode 4 goes to 2 if low-speed-on is 1, and to 0 otherwise.
  - an interrupt in modes 0 and 2 has no effect.
- R8: A sleep strobe in mode 0 or 2 whose bits match no rule of R5 or R6 leaves the mode unchanged and sets `illegalFlag`, which stays set until `rst_n`. A strobe in any other mode is ignored and does not set the flag.
- R9: `mainClkEn` is 1 exactly in modes 0, 1 and 7. `subClkSel` is 1 exactly in modes 2, 3 and 4.
- R10: `periphClkEn` is all ones in modes 0, 1 and 7. In modes 2, 3 and 4 only bits 0 to 3 are set: the two timers and the two watchdogs. In modes 5 and 6 it is all zeros.
- R11: `cfgErr` is 1 exactly when mode is 2 and `clkDiv` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sleepStrobe | input | 1 | One-cycle sleep instruction strobe |
| stbySel | input | 1 | Standby-select configuration bit |
| dirXfer | input | 1 | Direct-transfer configuration bit |
| lowSpdOn | input | 1 | Low-speed-on configuration bit |
| pscSel | input | 1 | Watchdog prescaler-select bit |
| clkDiv | input | DIVW | System clock divider field |
| irqPend | input | 1 | Interrupt pending |
| resetPin_n | input | 1 | Reset pin, active low |
| stbyPin_n | input | 1 | Hardware standby pin, active low |
| settleCount | input | CW | Oscillator settling time in cycles |
| mode | output | 3 | Current mode code |
| mainClkEn | output | 1 | Main clock enable |
| subClkSel | output | 1 | CPU runs from the subclock |
| periphClkEn | output | NGRP | Per-group peripheral clock enables |
| resetReq | output | 1 | One-cycle reset exception request |
| cfgErr | output | 1 | Nonzero divider while in subactive |
| illegalFlag | output | 1 | Sticky undefined-transition flag |

## Verification
The hardest situation to reach is a reset pin released before the settling count has elapsed. The exit must then wait for the counter, with the pin already high, so the rise of `resetReq` is set by the count and not by the pin. Random traffic rarely holds the reset pin low long enough and then lets it go early. A directed sequence therefore sets a settling time of six cycles, releases the pin after two and checks that the exit and its request come on the right edge. Further directed sequences walk high-speed to subactive, subsleep, watch and back, and assert both pins at once. A seeded random phase then mixes strobes, interrupts, pin pulses and divider values against a bench model.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    M_HIGH   = 3'd0,
    M_SLEEP  = 3'd1,
    M_SUBACT = 3'd2,
    M_SUBSLP = 3'd3,
    M_WATCH  = 3'd4,
    M_SWSTBY = 3'd5,
    M_HWSTBY = 3'd6,
    M_RESET  = 3'd7
  } pwrMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic setIllegal;
    logic fireReset;
  } ctlStrobe_t;

endpackage

// File: rtl/pwr_ctrl_fsm.sv
module pwr_ctrl_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleepStrobe,
  input  logic       stbySel,
  input  logic       dirXfer,
  input  logic       lowSpdOn,
  input  logic       pscSel,
  input  logic       irqPend,
  input  logic       resetPin_n,
  input  logic       stbyPin_n,
  input  logic       settleDone,
  output pwrMode_t   modeQ,
  output ctlStrobe_t strobe
);

  pwrMode_t modeNxt;
  logic     illegal;

  always_comb begin
    modeNxt = modeQ;
    illegal = 1'b0;
    if (!stbyPin_n) begin
      modeNxt = M_HWSTBY;                        // R2
    end else if (!resetPin_n || modeQ == M_HWSTBY) begin
      modeNxt = M_RESET;                         // R3
    end else begin
      unique case (modeQ)
        M_RESET: if (settleDone) modeNxt = M_HIGH;
        M_HIGH: if (sleepStrobe) begin           // R5
          if (!stbySel)                 modeNxt = M_SLEEP;
          else if (!dirXfer)            modeNxt = pscSel ? M_WATCH : M_SWSTBY;
          else if (lowSpdOn && pscSel)  modeNxt = M_SUBACT;
          else                          illegal = 1'b1;
        end
        M_SUBACT: if (sleepStrobe) begin         // R6
          if (!pscSel)                              illegal = 1'b1;
          else if (stbySel && !dirXfer)             modeNxt = M_WATCH;
          else if (!stbySel && lowSpdOn)            modeNxt = M_SUBSLP;
          else if (stbySel && dirXfer && !lowSpdOn) modeNxt = M_HIGH;
          else                                      illegal = 1'b1;
        end
        M_SLEEP, M_SWSTBY: if (irqPend) modeNxt = M_HIGH;
        M_SUBSLP:          if (irqPend) modeNxt = M_SUBACT;
        M_WATCH:           if (irqPend) modeNxt = lowSpdOn ? M_SUBACT : M_HIGH;
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.cntClear   = (modeNxt == M_RESET) && (modeQ != M_RESET);
    strobe.cntRun     = (modeNxt == M_RESET) && (modeQ == M_RESET);
    strobe.setIllegal = illegal;
    strobe.fireReset  = (modeQ == M_RESET) && (modeNxt == M_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modeQ <= M_RESET;
    else        modeQ <= modeNxt;
  end

endmodule

// File: rtl/pwr_datapath.sv
module pwr_datapath
  import pwr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctlStrobe_t    strobe,
  input  logic [CW-1:0] settleCount,
  output logic          settleDone,
  output logic          resetReq,
  output logic          illegalFlag
);

  logic [CW-1:0] settleCnt;

  assign settleDone = (settleCnt >= settleCount);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settleCnt   <= '0;
      resetReq    <= 1'b0;
      illegalFlag <= 1'b0;
    end else begin
      if (strobe.cntClear)
        settleCnt <= '0;
      else if (strobe.cntRun && !settleDone)
        settleCnt <= settleCnt + 1'b1;
      resetReq <= strobe.fireReset;
      if (strobe.setIllegal) illegalFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_clk_decode.sv
module pwr_clk_decode
  import pwr_pkg::*;
#(
  parameter int NGRP = 8,
  parameter int KEEP = 4
) (
  input  pwrMode_t        modeQ,
  input  logic [2:0]      clkDivIsSet,
  output logic            mainClkEn,
  output logic            subClkSel,
  output logic [NGRP-1:0] periphClkEn,
  output logic            cfgErr
);

  logic fullRun;
  logic lowRun;

  assign fullRun   = (modeQ == M_HIGH) || (modeQ == M_SLEEP) || (modeQ == M_RESET);
  assign lowRun    = (modeQ == M_SUBACT) || (modeQ == M_SUBSLP) || (modeQ == M_WATCH);
  assign mainClkEn = fullRun;
  assign subClkSel = lowRun;
  assign cfgErr    = (modeQ == M_SUBACT) && (|clkDivIsSet);

  for (genvar g = 0; g < NGRP; g++) begin : gGrp
    if (g < KEEP) begin : gKeep
      assign periphClkEn[g] = fullRun || lowRun;
    end else begin : gMain
      assign periphClkEn[g] = fullRun;
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int CW   = 8,
  parameter int DIVW = 3,
  parameter int NGRP = 8,
  parameter int KEEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleepStrobe,
  input  logic            stbySel,
  input  logic            dirXfer,
  input  logic            lowSpdOn,
  input  logic            pscSel,
  input  logic [DIVW-1:0] clkDiv,
  input  logic            irqPend,
  input  logic            resetPin_n,
  input  logic            stbyPin_n,
  input  logic [CW-1:0]   settleCount,
  output logic [2:0]      mode,
  output logic            mainClkEn,
  output logic            subClkSel,
  output logic [NGRP-1:0] periphClkEn,
  output logic            resetReq,
  output logic            cfgErr,
  output logic            illegalFlag
);

  pwrMode_t   modeQ;
  ctlStrobe_t strobe;
  logic       settleDone;
  logic [2:0] divSet;

  assign divSet = {2'b00, |clkDiv};
  assign mode   = modeQ;

  pwr_ctrl_fsm u_fsm (
    .clk, .rst_n, .sleepStrobe, .stbySel, .dirXfer, .lowSpdOn, .pscSel,
    .irqPend, .resetPin_n, .stbyPin_n, .settleDone,
    .modeQ(modeQ), .strobe(strobe)
  );

  pwr_datapath #(.CW(CW)) u_dp (
    .clk, .rst_n, .strobe(strobe), .settleCount,
    .settleDone(settleDone), .resetReq(resetReq), .illegalFlag(illegalFlag)
  );

  pwr_clk_decode #(.NGRP(NGRP), .KEEP(KEEP)) u_dec (
    .modeQ(modeQ), .clkDivIsSet(divSet),
    .mainClkEn(mainClkEn), .subClkSel(subClkSel),
    .periphClkEn(periphClkEn), .cfgErr(cfgErr)
  );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irqPend,
  input logic       resetPin_n,
  input logic       stbyPin_n,
  input logic [2:0] mode,
  input logic       mainClkEn,
  input logic       subClkSel,
  input logic       resetReq,
  input logic       cfgErr,
  input logic       illegalFlag
);

  a_r2_standby_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !stbyPin_n |=> mode == 3'd6);

  a_r3_reset_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (stbyPin_n && !resetPin_n) |=> mode == 3'd7);

  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |=> !resetReq);

  a_r4_req_from_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetReq) |-> (mode == 3'd0) && ($past(mode) == 3'd7));

  a_r7_subsleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && irqPend && stbyPin_n && resetPin_n) |=> mode == 3'd2);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    illegalFlag |=> illegalFlag);

  a_r9_clk_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mainClkEn && subClkSel));

  a_r11_cfg_only_subact: assert property (@(posedge clk) disable iff (!rst_n)
    cfgErr |-> mode == 3'd2);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk, .rst_n, .irqPend, .resetPin_n, .stbyPin_n, .mode,
  .mainClkEn, .subClkSel, .resetReq, .cfgErr, .illegalFlag
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int NGRP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepStrobe = 0, stbySel = 0, dirXfer = 0, lowSpdOn = 0, pscSel = 0;
  logic [2:0] clkDiv = '0;
  logic irqPend = 0, resetPin_n = 1, stbyPin_n = 1;
  logic [CW-1:0] settleCount = 8'd3;
  logic [2:0] mode;
  logic mainClkEn, subClkSel, resetReq, cfgErr, illegalFlag;
  logic [NGRP-1:0] periphClkEn;

  int nChecks = 0;
  int nFails = 0;

  // bench model state
  logic [2:0] mMode;
  int mCnt;
  logic mIll, mReq;
  string mTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk, .rst_n, .sleepStrobe, .stbySel, .dirXfer, .lowSpdOn, .pscSel,
    .clkDiv, .irqPend, .resetPin_n, .stbyPin_n, .settleCount,
    .mode, .mainClkEn, .subClkSel, .periphClkEn, .resetReq, .cfgErr, .illegalFlag
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // R9/R10 expected enables
  function automatic logic expMain(input logic [2:0] m);
    return m == 3'd0 || m == 3'd1 || m == 3'd7;
  endfunction
  function automatic logic expSub(input logic [2:0] m);
    return m == 3'd2 || m == 3'd3 || m == 3'd4;
  endfunction
  function automatic logic [NGRP-1:0] expPer(input logic [2:0] m);
    if (expMain(m)) return '1;
    if (expSub(m))  return NGRP'(4'hF);
    return '0;
  endfunction

  // next state of the model from the inputs now applied
  task automatic modelStep();
    logic [2:0] n;
    logic ill;
    n = mMode; ill = 1'b0; mReq = 1'b0; mTag = "R7";
    if (!stbyPin_n) begin
      n = 3'd6; mTag = "R2";
    end else if (!resetPin_n || mMode == 3'd6) begin
      n = 3'd7; mTag = (mMode == 3'd6 && resetPin_n) ? "R2" : "R3";
    end else begin
      case (mMode)
        3'd7: begin
          mTag = "R4";
          if (mCnt >= int'(settleCount)) begin n = 3'd0; mReq = 1'b1; end
        end
        3'd0: if (sleepStrobe) begin
          mTag = "R5";
          if (!stbySel) n = 3'd1;
          else if (!dirXfer) n = pscSel ? 3'd4 : 3'd5;
          else if (lowSpdOn && pscSel) n = 3'd2;
          else begin ill = 1'b1; mTag = "R8"; end
        end
        3'd2: if (sleepStrobe) begin
          mTag = "R6";
          if (pscSel && stbySel && !dirXfer) n = 3'd4;
          else if (pscSel && !stbySel && lowSpdOn) n = 3'd3;
          else if (pscSel && stbySel && dirXfer && !lowSpdOn) n = 3'd0;
          else begin ill = 1'b1; mTag = "R8"; end
        end
        3'd1, 3'd5: if (irqPend) n = 3'd0;
        3'd3: if (irqPend) n = 3'd2;
        3'd4: if (irqPend) n = lowSpdOn ? 3'd2 : 3'd0;
        default: ;
      endcase
    end
    if (n == 3'd7 && mMode != 3'd7) mCnt = 0;
    else if (n == 3'd7 && mCnt < int'(settleCount)) mCnt++;
    mMode = n;
    if (ill) mIll = 1'b1;
  endtask

  task automatic compareAll();
    check(mTag, 32'(mode), 32'(mMode));
    check("R4 resetReq", 32'(resetReq), 32'(mReq));
    check("R8 illegalFlag", 32'(illegalFlag), 32'(mIll));
    check("R9 mainClkEn", 32'(mainClkEn), 32'(expMain(mMode)));
    check("R9 subClkSel", 32'(subClkSel), 32'(expSub(mMode)));
    check("R10 periphClkEn", 32'(periphClkEn), 32'(expPer(mMode)));
    check("R11 cfgErr", 32'(cfgErr), 32'(mMode == 3'd2 && clkDiv != 0));
  endtask

  // inputs set at negedge before the call; one edge later outputs are compared
  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    sleepStrobe = 1'b0;
    irqPend = 1'b0;
  endtask

  task automatic strobeCfg(input logic s, input logic d, input logic l, input logic p);
    stbySel = s; dirXfer = d; lowSpdOn = l; pscSel = p; sleepStrobe = 1'b1;
    step();
  endtask

  task automatic wake(input logic l);
    lowSpdOn = l; irqPend = 1'b1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    mMode = 3'd7; mCnt = 0; mIll = 1'b0; mReq = 1'b0; mTag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 mode", 32'(mode), 32'd7);
    check("R1 resetReq", 32'(resetReq), 32'd0);
    check("R1 illegalFlag", 32'(illegalFlag), 32'd0);

    // R4 early release: settle 6, pin low two cycles then high
    settleCount = 8'd6;
    resetPin_n = 1'b0; step(); step();
    resetPin_n = 1'b1;
    for (int i = 0; i < 8; i++) step();
    check("R4 exited to high", 32'(mode), 32'd0);

    // R5 direct to subactive, R6 and R7 chain
    strobeCfg(1, 1, 1, 1);
    check("R5 high->subact", 32'(mode), 32'd2);
    clkDiv = 3'd2; step();
    check("R11 cfgErr in subact", 32'(cfgErr), 32'd1);
    clkDiv = 3'd0;
    strobeCfg(0, 0, 1, 1);
    check("R6 subact->subsleep", 32'(mode), 32'd3);
    wake(0);
    check("R7 subsleep->subact", 32'(mode), 32'd2);
    strobeCfg(1, 0, 0, 1);
    check("R6 subact->watch", 32'(mode), 32'd4);
    wake(1);
    check("R7 watch->subact", 32'(mode), 32'd2);
    strobeCfg(1, 1, 1, 1);
    check("R8 illegal in subact", 32'(illegalFlag), 32'd1);
    check("R8 mode unchanged", 32'(mode), 32'd2);
    strobeCfg(1, 1, 0, 1);
    check("R6 subact->high", 32'(mode), 32'd0);
    strobeCfg(1, 0, 0, 0);
    check("R5 high->swstby", 32'(mode), 32'd5);
    strobeCfg(0, 0, 0, 0);
    check("R8 strobe ignored in standby", 32'(mode), 32'd5);

    // R2 both pins low: standby wins
    stbyPin_n = 1'b0; resetPin_n = 1'b0; step();
    check("R2 standby over reset", 32'(mode), 32'd6);
    stbyPin_n = 1'b1; resetPin_n = 1'b1; step();
    check("R2 standby release -> reset", 32'(mode), 32'd7);

    // random phase
    settleCount = 8'd3;
    for (int i = 0; i < 3000; i++) begin
      sleepStrobe = ($urandom_range(0, 9) < 3);
      {stbySel, dirXfer, lowSpdOn, pscSel} = 4'($urandom_range(0, 15));
      irqPend = ($urandom_range(0, 9) < 2);
      resetPin_n = ($urandom_range(0, 99) >= 3);
      stbyPin_n = ($urandom_range(0, 99) >= 2);
      clkDiv = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      if (i == 1500) settleCount = 8'd0;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule